// File: doc/BRIEF.md
# Memory Map Access Response Checker

This block sits on the bus side of a memory system. For every access presented to it (an address, an access kind and a valid strobe) it decides whether the access succeeds or fails. The response is registered and comes back exactly one clock later. The decode sorts the 32-bit address into flash main memory, flash information memory, SRAM (two windows), ROM (with a guarded low page), peripherals, bit-band alias windows and reserved space. Each region has its own rules for reads, writes and instruction fetches.

The flash regions also follow per-sector write-protection masks and a per-sector secure mask on main flash. A write to a protected sector still answers OK, but its commit flag stays low, so the storage side discards it. A read from a bit-band alias window returns a byte holding the addressed bit. The bit comes from the target word that the memory side supplies with the access. The block does not produce any other memory data.

Top module: `mem_access_gate`

## Requirements
- R1: An accepted access (`req_valid` high while `req_ready` is high) gives `rsp_valid` high on the next cycle. `rsp_valid` is low on any cycle that does not follow an accepted access.
- R2: Flash main (0x0000_0000–0x0003_FFFF), flash information (0x0020_0000–0x0020_3FFF) and SRAM (0x0100_0000–0x0100_FFFF, 0x2000_0000–0x2000_FFFF) answer OK to read (kind 0), write (kind 1) and fetch (kind 2), subject to R6 and R7.
- R3: ROM at 0x0200_0400–0x0200_7FFF answers OK to read and fetch and error to write. Its low page 0x0200_0000–0x0200_03FF answers error to every kind.
- R4: Peripherals (0x4000_0000–0x4001_FFFF) and the bit-band alias windows (0x2200_0000–0x23FF_FFFF, 0x4200_0000–0x43FF_FFFF) answer OK to read and write and error to fetch.
- R5: An OK read in an alias window returns `rsp_rdata` = 0x01 when bit addr[6:2] of `tgt_word` is set and 0x00 when it is clear. Every other response carries `rsp_rdata` = 0x00.
- R6: A write that answers OK raises `rsp_commit`, except when it targets a flash sector whose write-protect bit is set. Such a write answers OK with `rsp_commit` low. The main sector is addr[17:12] (bit of `wp_main`). The information sector is addr[13:12] (bit of `wp_info`). Reads and fetches never raise `rsp_commit`.
- R7: When `src_trusted` is low, any access to a main flash sector whose `sec_main` bit (index addr[17:12]) is set answers error. The secure mask has no effect when `src_trusted` is high or outside main flash.
- R8: Every address outside the listed regions, and access kind code 3 at any address, answers error.
- R9: While `rst_n` is low all outputs are low. `req_ready` rises on the first clock edge after reset release.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Access present this cycle |
| req_ready | output | 1 | Block accepts accesses |
| req_addr | input | 32 | Byte address of the access |
| req_kind | input | 2 | 0 read, 1 write, 2 fetch, 3 invalid |
| wp_main | input | 64 | Write-protect bit per 4 KB main flash sector |
| wp_info | input | 4 | Write-protect bit per 4 KB information flash sector |
| sec_main | input | 64 | Secure bit per 4 KB main flash sector |
| src_trusted | input | 1 | Access source is authorized for secure sectors |
| tgt_word | input | 32 | Target word behind a bit-band alias access |
| rsp_valid | output | 1 | Response present |
| rsp_err | output | 1 | Access answered with error |
| rsp_commit | output | 1 | Write takes effect in storage |
| rsp_rdata | output | 8 | Bit-band read byte, else zero |

## Verification
Every result (error flag, commit flag and bit-band byte) is due in the cycle right after the access is accepted, because there is one register stage between request and response. The bench drives each access on a falling edge and compares the response on the next falling edge, half a period after the capturing edge. It then drops or replaces the request, so each response is matched against exactly one access. `req_ready` is due one edge after reset release. Idle-cycle checks confirm that `rsp_valid` falls when no access came before.

// File: rtl/mag_pkg.sv
package mag_pkg;

  typedef enum logic [1:0] {
    ACC_READ  = 2'd0,
    ACC_WRITE = 2'd1,
    ACC_FETCH = 2'd2,
    ACC_BAD   = 2'd3
  } acc_kind_e;

  typedef enum logic [2:0] {
    RG_RSVD   = 3'd0,
    RG_FMAIN  = 3'd1,
    RG_FINFO  = 3'd2,
    RG_SRAM   = 3'd3,
    RG_ROM    = 3'd4,
    RG_ROMLOW = 3'd5,
    RG_PERIPH = 3'd6,
    RG_ALIAS  = 3'd7
  } region_e;

  // Region tags: upper address bits that identify each window.
  localparam logic [13:0] TAG_FMAIN  = 14'h0000;   // addr[31:18]
  localparam logic [17:0] TAG_FINFO  = 18'h00080;  // addr[31:14]
  localparam logic [15:0] TAG_SRAM_C = 16'h0100;   // addr[31:16]
  localparam logic [15:0] TAG_SRAM_S = 16'h2000;   // addr[31:16]
  localparam logic [16:0] TAG_ROM    = 17'h00400;  // addr[31:15]
  localparam logic [14:0] TAG_PERIPH = 15'h2000;   // addr[31:17]
  localparam logic [6:0]  TAG_ALIAS0 = 7'h11;      // addr[31:25]
  localparam logic [6:0]  TAG_ALIAS1 = 7'h21;      // addr[31:25]

endpackage

// File: rtl/mag_region_decode.sv
module mag_region_decode
  import mag_pkg::*;
#(
  parameter int SECT_W = 12,
  localparam int MAIN_IW = 18 - SECT_W,
  localparam int INFO_IW = 14 - SECT_W
) (
  input  logic [31:0]        addr,
  output region_e            region,
  output logic [MAIN_IW-1:0] main_idx,
  output logic [INFO_IW-1:0] info_idx
);

  always_comb begin
    region = RG_RSVD;
    if (addr[31:18] == TAG_FMAIN) begin
      region = RG_FMAIN;
    end else if (addr[31:14] == TAG_FINFO) begin
      region = RG_FINFO;
    end else if ((addr[31:16] == TAG_SRAM_C) || (addr[31:16] == TAG_SRAM_S)) begin
      region = RG_SRAM;
    end else if (addr[31:15] == TAG_ROM) begin
      region = (addr[14:10] == 5'd0) ? RG_ROMLOW : RG_ROM;
    end else if (addr[31:17] == TAG_PERIPH) begin
      region = RG_PERIPH;
    end else if ((addr[31:25] == TAG_ALIAS0) || (addr[31:25] == TAG_ALIAS1)) begin
      region = RG_ALIAS;
    end
  end

  assign main_idx = addr[17:SECT_W];
  assign info_idx = addr[13:SECT_W];

endmodule

// File: rtl/mag_policy.sv
module mag_policy
  import mag_pkg::*;
#(
  parameter int SECT_W = 12,
  localparam int MAIN_IW   = 18 - SECT_W,
  localparam int INFO_IW   = 14 - SECT_W,
  localparam int MAIN_SECT = 1 << MAIN_IW,
  localparam int INFO_SECT = 1 << INFO_IW
) (
  input  region_e              region,
  input  acc_kind_e            kind,
  input  logic [MAIN_IW-1:0]   main_idx,
  input  logic [INFO_IW-1:0]   info_idx,
  input  logic [MAIN_SECT-1:0] wp_main,
  input  logic [INFO_SECT-1:0] wp_info,
  input  logic [MAIN_SECT-1:0] sec_main,
  input  logic                 trusted,
  output logic                 err,
  output logic                 commit
);

  logic allow;
  logic blocked;
  logic locked;

  always_comb begin
    unique case (region)
      RG_FMAIN, RG_FINFO, RG_SRAM: allow = (kind != ACC_BAD);
      RG_ROM:                      allow = (kind == ACC_READ) || (kind == ACC_FETCH);
      RG_PERIPH, RG_ALIAS:         allow = (kind == ACC_READ) || (kind == ACC_WRITE);
      default:                     allow = 1'b0;
    endcase
  end

  always_comb begin
    blocked = (region == RG_FMAIN) && sec_main[main_idx] && !trusted;
    locked  = ((region == RG_FMAIN) && wp_main[main_idx]) ||
              ((region == RG_FINFO) && wp_info[info_idx]);
    err     = !allow || blocked;
    commit  = !err && (kind == ACC_WRITE) && !locked;
  end

endmodule

// File: rtl/mag_bitband_pick.sv
module mag_bitband_pick
  import mag_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int WORD_W = 32,
  localparam int SEL_W = $clog2(WORD_W)
) (
  input  logic [31:0]       addr,
  input  logic [WORD_W-1:0] word,
  input  region_e           region,
  input  acc_kind_e         kind,
  input  logic              err,
  output logic [DATA_W-1:0] rdata
);

  logic [SEL_W-1:0] sel;
  logic             hit;

  assign sel = addr[SEL_W+1:2];
  assign hit = (region == RG_ALIAS) && (kind == ACC_READ) && !err;

  always_comb begin
    rdata    = '0;
    rdata[0] = hit & word[sel];
  end

endmodule

// File: rtl/mem_access_gate.sv
module mem_access_gate
  import mag_pkg::*;
#(
  parameter int SECT_W = 12,
  parameter int DATA_W = 8,
  localparam int MAIN_IW   = 18 - SECT_W,
  localparam int INFO_IW   = 14 - SECT_W,
  localparam int MAIN_SECT = 1 << MAIN_IW,
  localparam int INFO_SECT = 1 << INFO_IW
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 req_valid,
  output logic                 req_ready,
  input  logic [31:0]          req_addr,
  input  logic [1:0]           req_kind,
  input  logic [MAIN_SECT-1:0] wp_main,
  input  logic [INFO_SECT-1:0] wp_info,
  input  logic [MAIN_SECT-1:0] sec_main,
  input  logic                 src_trusted,
  input  logic [31:0]          tgt_word,
  output logic                 rsp_valid,
  output logic                 rsp_err,
  output logic                 rsp_commit,
  output logic [DATA_W-1:0]    rsp_rdata
);

  region_e            region;
  acc_kind_e          kind;
  logic [MAIN_IW-1:0] main_idx;
  logic [INFO_IW-1:0] info_idx;
  logic               err_c;
  logic               commit_c;
  logic [DATA_W-1:0]  rdata_c;

  assign kind = acc_kind_e'(req_kind);

  mag_region_decode #(.SECT_W(SECT_W)) decode_i (
    .addr     (req_addr),
    .region   (region),
    .main_idx (main_idx),
    .info_idx (info_idx)
  );

  mag_policy #(.SECT_W(SECT_W)) policy_i (
    .region   (region),
    .kind     (kind),
    .main_idx (main_idx),
    .info_idx (info_idx),
    .wp_main  (wp_main),
    .wp_info  (wp_info),
    .sec_main (sec_main),
    .trusted  (src_trusted),
    .err      (err_c),
    .commit   (commit_c)
  );

  mag_bitband_pick #(.DATA_W(DATA_W), .WORD_W(32)) pick_i (
    .addr   (req_addr),
    .word   (tgt_word),
    .region (region),
    .kind   (kind),
    .err    (err_c),
    .rdata  (rdata_c)
  );

  // State and next-state
  logic              rdy_q,    rdy_d;
  logic              vld_q,    vld_d;
  logic              err_q,    err_d;
  logic              cmt_q,    cmt_d;
  logic [DATA_W-1:0] dat_q,    dat_d;
  logic              accept;

  assign accept = req_valid && rdy_q;

  always_comb begin
    rdy_d = 1'b1;
    vld_d = accept;
    err_d = err_c;
    cmt_d = commit_c;
    dat_d = rdata_c;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdy_q <= 1'b0;
      vld_q <= 1'b0;
    end else begin
      rdy_q <= rdy_d;
      vld_q <= vld_d;
    end
  end

  // Payload loads only on an accepted access
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      err_q <= 1'b0;
      cmt_q <= 1'b0;
      dat_q <= '0;
    end else if (accept) begin
      err_q <= err_d;
      cmt_q <= cmt_d;
      dat_q <= dat_d;
    end
  end

  assign req_ready  = rdy_q;
  assign rsp_valid  = vld_q;
  assign rsp_err    = err_q;
  assign rsp_commit = cmt_q;
  assign rsp_rdata  = dat_q;

endmodule

// File: rtl/mag_checker.sv
module mag_checker #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_ready,
  input logic [31:0]       req_addr,
  input logic [1:0]        req_kind,
  input logic              rsp_valid,
  input logic              rsp_err,
  input logic              rsp_commit,
  input logic [DATA_W-1:0] rsp_rdata
);

  logic acc;
  assign acc = req_valid && req_ready;

  assert_rsp_follows_R1: assert property (@(posedge clk) disable iff (!rst_n)
    acc |=> rsp_valid);

  assert_no_spurious_rsp_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !acc |=> !rsp_valid);

  assert_rom_write_err_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && req_kind == 2'd1 && req_addr[31:16] == 16'h0200) |=> rsp_err);

  assert_fetch_high_err_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && req_kind == 2'd2 && req_addr[31:28] == 4'h4) |=> rsp_err);

  assert_rdata_single_bit_R5: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> (rsp_rdata[DATA_W-1:1] == '0));

  assert_err_no_data_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_err) |-> (rsp_rdata == '0));

  assert_commit_clean_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_commit) |-> !rsp_err);

  assert_commit_write_only_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && req_kind != 2'd1) |=> !rsp_commit);

  assert_bad_kind_err_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && req_kind == 2'd3) |=> rsp_err);

  assert_ready_rises_R9: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |=> req_ready);

endmodule

bind mem_access_gate mag_checker #(.DATA_W(DATA_W)) chk_i (.*);

// File: tb/mem_access_gate_tb_top.sv
module mem_access_gate_tb_top;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        req_valid;
  logic        req_ready;
  logic [31:0] req_addr;
  logic [1:0]  req_kind;
  logic [63:0] wp_main;
  logic [3:0]  wp_info;
  logic [63:0] sec_main;
  logic        src_trusted;
  logic [31:0] tgt_word;
  logic        rsp_valid;
  logic        rsp_err;
  logic        rsp_commit;
  logic [7:0]  rsp_rdata;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #5 clk = ~clk;

  mem_access_gate dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .req_kind(req_kind), .wp_main(wp_main), .wp_info(wp_info),
    .sec_main(sec_main), .src_trusted(src_trusted), .tgt_word(tgt_word),
    .rsp_valid(rsp_valid), .rsp_err(rsp_err), .rsp_commit(rsp_commit),
    .rsp_rdata(rsp_rdata)
  );

  function automatic void model(input logic [31:0] a, input logic [1:0] k,
                                output logic e, output logic c, output logic [7:0] d);
    int rg;  // 0 reserved, 1 main, 2 info, 3 sram, 4 rom, 5 periph, 6 alias
    logic ok, lock;
    int sect;
    rg = 0;
    if (a <= 32'h0003_FFFF) rg = 1;
    else if (a >= 32'h0020_0000 && a <= 32'h0020_3FFF) rg = 2;
    else if ((a >= 32'h0100_0000 && a <= 32'h0100_FFFF) ||
             (a >= 32'h2000_0000 && a <= 32'h2000_FFFF)) rg = 3;
    else if (a >= 32'h0200_0400 && a <= 32'h0200_7FFF) rg = 4;
    else if (a >= 32'h4000_0000 && a <= 32'h4001_FFFF) rg = 5;
    else if ((a >= 32'h2200_0000 && a <= 32'h23FF_FFFF) ||
             (a >= 32'h4200_0000 && a <= 32'h43FF_FFFF)) rg = 6;
    ok = 1'b0;
    if (rg >= 1 && rg <= 3) ok = (k != 2'd3);
    if (rg == 4) ok = (k == 2'd0 || k == 2'd2);
    if (rg >= 5) ok = (k == 2'd0 || k == 2'd1);
    lock = 1'b0;
    if (rg == 1) begin
      sect = int'(a / 4096);
      if (sec_main[sect] && !src_trusted) ok = 1'b0;
      lock = wp_main[sect];
    end
    if (rg == 2) begin
      sect = int'((a - 32'h0020_0000) / 4096);
      lock = wp_info[sect];
    end
    e = !ok;
    c = ok && (k == 2'd1) && !lock;
    d = 8'h00;
    if (ok && rg == 6 && k == 2'd0) d = {7'd0, tgt_word[(a / 4) % 32]};
  endfunction

  function automatic string tag_of(input logic [31:0] a, input logic [1:0] k);
    if (k == 2'd3) return "R8";
    if (a[31:16] == 16'h0200) return "R3";
    if (a[31:28] == 4'h4 || a[31:25] == 7'h11) return "R4";
    return "R2/R8";
  endfunction

  task automatic check1(input string tag, input string what, input logic [31:0] act,
                        input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  // Drive at a falling edge, check the registered response one period later.
  task automatic access(input logic [31:0] a, input logic [1:0] k, input string tag);
    logic e, c;
    logic [7:0] d;
    req_valid = 1'b1;
    req_addr  = a;
    req_kind  = k;
    model(a, k, e, c, d);
    @(negedge clk);
    req_valid = 1'b0;
    check1("R1", "rsp_valid", {31'd0, rsp_valid}, 32'd1);
    check1(tag, $sformatf("err a=%h k=%0d", a, k), {31'd0, rsp_err}, {31'd0, e});
    check1(tag, $sformatf("commit a=%h k=%0d", a, k), {31'd0, rsp_commit}, {31'd0, c});
    check1(tag, $sformatf("rdata a=%h k=%0d", a, k), {24'd0, rsp_rdata}, {24'd0, d});
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  logic [31:0] sweep [0:31];

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    finish_run();
  end

  initial begin
    sweep[0]  = 32'h0000_0000; sweep[1]  = 32'h0003_FFFC; sweep[2]  = 32'h0004_0000;
    sweep[3]  = 32'h001F_FFFC; sweep[4]  = 32'h0020_0000; sweep[5]  = 32'h0020_3FFC;
    sweep[6]  = 32'h0020_4000; sweep[7]  = 32'h0100_0000; sweep[8]  = 32'h0100_FFFC;
    sweep[9]  = 32'h0101_0000; sweep[10] = 32'h0200_0000; sweep[11] = 32'h0200_03FC;
    sweep[12] = 32'h0200_0400; sweep[13] = 32'h0200_7FFC; sweep[14] = 32'h0200_8000;
    sweep[15] = 32'h1FFF_FFFC; sweep[16] = 32'h2000_0000; sweep[17] = 32'h2000_FFFC;
    sweep[18] = 32'h2001_0000; sweep[19] = 32'h2200_0000; sweep[20] = 32'h23FF_FFFC;
    sweep[21] = 32'h2400_0000; sweep[22] = 32'h4000_0000; sweep[23] = 32'h4001_FFFC;
    sweep[24] = 32'h4002_0000; sweep[25] = 32'h4200_0044; sweep[26] = 32'h43FF_FFFC;
    sweep[27] = 32'h4400_0000; sweep[28] = 32'hDFFF_FFFC; sweep[29] = 32'hFFFF_FFFC;
    sweep[30] = 32'h0002_1000; sweep[31] = 32'h2300_0010;

    rst_n = 1'b0; req_valid = 1'b0; req_addr = '0; req_kind = '0;
    wp_main = '0; wp_info = '0; sec_main = '0; src_trusted = 1'b1; tgt_word = '0;
    repeat (3) @(negedge clk);
    // R9: reset state
    check1("R9", "ready in reset", {31'd0, req_ready}, 32'd0);
    check1("R9", "outputs in reset",
           {21'd0, rsp_valid, rsp_err, rsp_commit, rsp_rdata}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check1("R9", "ready after release", {31'd0, req_ready}, 32'd1);

    // R2, R3, R4, R8: region x kind sweep, two target words
    for (int w = 0; w < 2; w++) begin
      tgt_word = (w == 0) ? 32'h0000_0000 : 32'hFFFF_FFFF;
      for (int i = 0; i < 32; i++)
        for (int k = 0; k < 4; k++)
          access(sweep[i], k[1:0], tag_of(sweep[i], k[1:0]));
    end

    // R1: idle cycle gives no response
    @(negedge clk);
    check1("R1", "idle rsp_valid", {31'd0, rsp_valid}, 32'd0);

    // R5: every bit position of an alias word, both windows
    tgt_word = 32'hA5C3_0F69;
    for (int b = 0; b < 32; b++) begin
      access(32'h2200_0100 + b * 4, 2'd0, "R5");
      access(32'h4200_0000 + b * 4, 2'd0, "R5");
    end
    access(32'h2200_0004, 2'd1, "R5");
    access(32'h4200_0000, 2'd2, "R5");

    // R6: write protection
    wp_main = 64'h0000_0000_0000_0020;   // sector 5
    wp_info = 4'b0100;                   // sector 2
    access(32'h0000_5010, 2'd1, "R6");
    access(32'h0000_6010, 2'd1, "R6");
    access(32'h0000_5010, 2'd0, "R6");
    access(32'h0020_2000, 2'd1, "R6");
    access(32'h0020_1000, 2'd1, "R6");
    access(32'h2000_0010, 2'd1, "R6");
    for (int s = 0; s < 64; s++) begin
      wp_main = 64'd1 << s;
      access(s * 4096 + 32'h40, 2'd1, "R6");
      access(((s + 1) % 64) * 4096, 2'd1, "R6");
    end
    wp_main = '0; wp_info = '0;

    // R7: secure sectors
    sec_main = 64'h8000_0000_0000_0008;  // sectors 3 and 63
    src_trusted = 1'b0;
    for (int k = 0; k < 3; k++) begin
      access(32'h0000_3004, k[1:0], "R7");
      access(32'h0003_F000, k[1:0], "R7");
      access(32'h0000_4004, k[1:0], "R7");
      access(32'h0020_3000, k[1:0], "R7");
    end
    src_trusted = 1'b1;
    access(32'h0000_3004, 2'd0, "R7");
    access(32'h0000_3004, 2'd1, "R7");
    sec_main = '0;

    // R9: reset mid-run clears outputs
    req_valid = 1'b1; req_addr = 32'h4000_0000; req_kind = 2'd0;
    @(negedge clk);
    rst_n = 1'b0;
    req_valid = 1'b0;
    #1;
    check1("R9", "outputs after reset assert",
           {21'd0, rsp_valid, rsp_err, rsp_commit, rsp_rdata}, 32'd0);
    check1("R9", "ready after reset assert", {31'd0, req_ready}, 32'd0);

    finish_run();
  end

endmodule